// File: doc/BRIEF.md
# Codec Host Bus and Sample Transfer Interface

This block sits between an asynchronous byte-wide host bus and the sample side of an audio codec. The host reaches four direct locations with a two-bit address while chip select is low. One location is an index pointer and one is a data window into a bank of 21 byte-wide control registers. One holds interrupt status. The last is a programmed-I/O sample port. All strobes and qualifiers pass through a synchroniser into the internal clock. Every access takes effect when its strobe is released.

Two request/acknowledge pairs move samples without host register cycles. A capture sample from the converter side raises the capture request. The request stays high until every byte of that sample has been read under the capture acknowledge. A playback need pulse raises the playback request. That request stays high until every byte of one sample has been written under the playback acknowledge. The assembled sample word is then handed out with a valid pulse. Chip select plays no part in these acknowledged cycles. The byte count per sample follows the configured width and channel count. A 16-bit down-counter counts completed samples. When it wraps, it sets a sticky interrupt. The block also drives the enable and direction lines of an external bus transceiver straight from the bus pins.

The bus cycle machine has four states. BUS_IDLE goes to BUS_READ when the synchronised read strobe is low, or else to BUS_WRITE when the synchronised write strobe is low. BUS_READ and BUS_WRITE go to BUS_DONE when their strobe rises. BUS_DONE issues one commit and returns to BUS_IDLE. The capture lane goes from CAP_EMPTY to CAP_SEND when a sample arrives while capture is enabled. It returns to CAP_EMPTY on the last byte taken. The playback lane goes from PLAY_IDLE to PLAY_FILL on a need pulse while playback is enabled. It returns to PLAY_IDLE on the last byte given.

Top module: `codec_host_if`

## Requirements
- R1: `xcvr_en_n` is low exactly while a strobe (`rd_n` or `wr_n`) is low together with `cs_n` low or either acknowledge low. At all other times it is high.
- R2: `xcvr_dir` is low exactly while `rd_n` is low together with `cs_n` low or either acknowledge low. At all other times it is high.
- R3: A register cycle with `cs_n` high and both acknowledges high has no effect.
- R4: Address 0 holds a 5-bit index in bits 4:0 and reads back zero-padded. Address 1 reads and writes control register [index] for indices 0 to 20. An index of 21 or more reads 0x00, and writes to it are ignored.
- R5: With capture enabled (register 9 bit 1), a `cap_smp_vld` pulse in CAP_EMPTY latches `cap_smp` and raises `cap_req`. The request stays high until the sample's bytes have been read, lowest byte first, and then drops.
- R6: A read with `cap_ack_n` low, or a write with `play_ack_n` low, is a sample transfer whatever the level of `cs_n`.
- R7: With playback enabled (register 9 bit 0), a `play_need` pulse raises `play_req`. The request stays high until the sample's bytes have been written, lowest byte first. Then `play_smp` carries the assembled word, upper unused bytes zero, with a one-cycle `play_smp_vld`, and the request drops.
- R8: Bytes per sample are taken from register 8. Bit 6 selects 16-bit (else 8-bit) and bit 4 selects stereo (else mono), giving 1, 2 or 4 bytes.
- R9: Writing register 14 loads the count with {value, register 15}. Each completed sample decrements the count. A sample completing at count 0 sets `irq` and reloads the count from {register 14, register 15}.
- R10: Address 2 reads `irq` in bit 0. Any write to address 2 clears it, unless an underflow occurs in the same cycle.
- R11: Every access takes effect only after its strobe rises. During the final byte's strobe the request is still high.
- R12: With `cs_n` low, a read of address 3 returns and consumes the current capture byte, and a write to address 3 supplies a playback byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Direct register address |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host |
| xcvr_en_n | output | 1 | Transceiver enable, active low |
| xcvr_dir | output | 1 | Transceiver direction, high host-to-codec |
| cap_ack_n | input | 1 | Capture acknowledge, active low |
| cap_req | output | 1 | Capture transfer request |
| play_ack_n | input | 1 | Playback acknowledge, active low |
| play_req | output | 1 | Playback transfer request |
| irq | output | 1 | Sticky count-underflow interrupt |
| cap_smp_vld | input | 1 | Capture sample strobe |
| cap_smp | input | 32 | Capture sample word |
| play_need | input | 1 | Playback sample needed pulse |
| play_smp | output | 32 | Assembled playback sample |
| play_smp_vld | output | 1 | Playback sample valid pulse |

## Verification
The assertions assume that the host holds address, data, chip select and acknowledge steady for the whole time a strobe is low. They also assume that only one strobe is low at a time, so the commit lines can never carry more than one access. The stimulus sets up every qualifier one clock before the strobe falls and releases it one clock after the strobe rises. It leaves several idle clocks between cycles, so the synchroniser always sees a clean, single access.

// File: rtl/codec_host_pkg.sv
package codec_host_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_READ,
        BUS_WRITE,
        BUS_DONE
    } bus_state_t;

    typedef enum logic {
        CAP_EMPTY,
        CAP_SEND
    } cap_state_t;

    typedef enum logic {
        PLAY_IDLE,
        PLAY_FILL
    } play_state_t;

    // One completed host access, valid for a single clock
    typedef struct packed {
        logic       reg_rd;
        logic       reg_wr;
        logic       cap_rd;
        logic       play_wr;
        logic [1:0] addr;
        logic [7:0] data;
    } commit_t;

endpackage

// File: rtl/codec_bus_fsm.sv
module codec_bus_fsm
    import codec_host_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 2,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              cap_ack_n,
    input  logic              play_ack_n,
    output commit_t           cmt
);

    localparam int PIPE_W = 5 + ADDR_W + DATA_W;

    logic [PIPE_W-1:0] pipe [SYNC_STAGES];
    logic [PIPE_W-1:0] raw;
    logic [PIPE_W-1:0] s;

    assign raw = {rd_n, wr_n, cs_n, cap_ack_n, play_ack_n, addr, din};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) pipe[i] <= '1;
        end else begin
            pipe[0] <= raw;
            for (int i = 1; i < SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign s = pipe[SYNC_STAGES-1];

    logic              s_rd_n, s_wr_n;
    logic              s_cs_n, s_cack_n, s_pack_n;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_data;

    assign {s_rd_n, s_wr_n, s_cs_n, s_cack_n, s_pack_n, s_addr, s_data} = s;

    bus_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: begin
                if (!s_rd_n)      state_d = BUS_READ;
                else if (!s_wr_n) state_d = BUS_WRITE;
            end
            BUS_READ:  if (s_rd_n) state_d = BUS_DONE;
            BUS_WRITE: if (s_wr_n) state_d = BUS_DONE;
            BUS_DONE:  state_d = BUS_IDLE;
            default:   state_d = BUS_IDLE;
        endcase
    end

    // Qualifiers held from the last cycle the strobe was seen low
    logic              h_read, h_cs_n, h_cack_n, h_pack_n;
    logic [ADDR_W-1:0] h_addr;
    logic [DATA_W-1:0] h_data;
    logic              strobe_low;

    assign strobe_low = (state_q != BUS_DONE) && (!s_rd_n || !s_wr_n);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_read   <= 1'b0;
            h_cs_n   <= 1'b1;
            h_cack_n <= 1'b1;
            h_pack_n <= 1'b1;
            h_addr   <= '0;
            h_data   <= '0;
        end else if (strobe_low) begin
            if (state_q == BUS_IDLE) h_read <= !s_rd_n;
            h_cs_n   <= s_cs_n;
            h_cack_n <= s_cack_n;
            h_pack_n <= s_pack_n;
            h_addr   <= s_addr;
            h_data   <= s_data;
        end
    end

    always_comb begin
        cmt      = '0;
        cmt.addr = h_addr;
        cmt.data = h_data;
        if (state_q == BUS_DONE) begin
            if (h_read) begin
                if (!h_cack_n)                  cmt.cap_rd = 1'b1;
                else if (h_pack_n && !h_cs_n)   cmt.reg_rd = 1'b1;
            end else begin
                if (!h_pack_n)                  cmt.play_wr = 1'b1;
                else if (h_cack_n && !h_cs_n)   cmt.reg_wr = 1'b1;
            end
        end
    end

    assert_commit_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmt.reg_rd, cmt.reg_wr, cmt.cap_rd, cmt.play_wr}));

    assert_commit_after_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt.reg_rd || cmt.reg_wr || cmt.cap_rd || cmt.play_wr) |-> (s_rd_n && s_wr_n));

endmodule

// File: rtl/codec_ctrl_regs.sv
module codec_ctrl_regs #(
    parameter int NUM_CTRL   = 21,
    parameter int IDX_W      = 5,
    parameter int FMT_IDX    = 8,
    parameter int IFC_IDX    = 9,
    parameter int CNT_HI_IDX = 14,
    parameter int CNT_LO_IDX = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [1:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             sample_done,
    output logic [IDX_W-1:0] idx_q,
    output logic [7:0]       data_rd,
    output logic [2:0]       nbytes,
    output logic             play_en,
    output logic             cap_en,
    output logic             irq
);

    localparam int CNT_W = 16;
    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(NUM_CTRL);

    logic [7:0]       bank [NUM_CTRL];
    logic [CNT_W-1:0] cnt_q;
    logic             in_range;
    logic             wr_index, wr_data_en, wr_status;
    logic [2:0]       width_bytes;

    assign in_range   = idx_q < LIMIT;
    assign wr_index   = wr_stb && (wr_addr == 2'd0);
    assign wr_data_en = wr_stb && (wr_addr == 2'd1) && in_range;
    assign wr_status  = wr_stb && (wr_addr == 2'd2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        idx_q <= '0;
        else if (wr_index) idx_q <= wr_data[IDX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CTRL; i++) bank[i] <= '0;
        end else if (wr_data_en) begin
            for (int i = 0; i < NUM_CTRL; i++)
                if (idx_q == IDX_W'(i)) bank[i] <= wr_data;
        end
    end

    always_comb begin
        data_rd = '0;
        for (int i = 0; i < NUM_CTRL; i++)
            if (idx_q == IDX_W'(i)) data_rd = bank[i];
    end

    assign width_bytes = bank[FMT_IDX][6] ? 3'd2 : 3'd1;
    assign nbytes      = bank[FMT_IDX][4] ? {width_bytes[1:0], 1'b0} : width_bytes;
    assign play_en     = bank[IFC_IDX][0];
    assign cap_en      = bank[IFC_IDX][1];

    logic load_cnt;
    assign load_cnt = wr_data_en && (idx_q == IDX_W'(CNT_HI_IDX));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            irq   <= 1'b0;
        end else begin
            if (load_cnt)
                cnt_q <= {wr_data, bank[CNT_LO_IDX]};
            else if (sample_done)
                cnt_q <= (cnt_q == '0) ? {bank[CNT_HI_IDX], bank[CNT_LO_IDX]} : cnt_q - 1'b1;

            if (sample_done && cnt_q == '0) irq <= 1'b1;
            else if (wr_status)             irq <= 1'b0;
        end
    end

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(sample_done));

    assert_status_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && !sample_done) |=> !irq);

endmodule

// File: rtl/codec_cap_lane.sv
module codec_cap_lane
    import codec_host_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              smp_vld,
    input  logic [WORD_W-1:0] smp,
    input  logic [2:0]        nbytes,
    input  logic              take,
    output logic              req,
    output logic [7:0]        byte_out,
    output logic              done
);

    localparam int NB    = WORD_W / 8;
    localparam int PTR_W = $clog2(NB);

    cap_state_t        state_q, state_d;
    logic [WORD_W-1:0] word_q;
    logic [PTR_W-1:0]  ptr_q, last_q;
    logic              at_last;

    assign at_last = ptr_q == last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAP_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_EMPTY: if (en && smp_vld)  state_d = CAP_SEND;
            CAP_SEND:  if (take && at_last) state_d = CAP_EMPTY;
            default:   state_d = CAP_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            ptr_q  <= '0;
            last_q <= '0;
        end else if (state_q == CAP_EMPTY && en && smp_vld) begin
            word_q <= smp;
            ptr_q  <= '0;
            last_q <= PTR_W'(nbytes - 3'd1);
        end else if (state_q == CAP_SEND && take && !at_last) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    always_comb begin
        req      = state_q == CAP_SEND;
        done     = (state_q == CAP_SEND) && take && at_last;
        byte_out = 8'(word_q >> {ptr_q, 3'b000});
    end

    assert_cap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req) |-> $past(take));

    assert_cap_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> ptr_q <= last_q);

endmodule

// File: rtl/codec_play_lane.sv
module codec_play_lane
    import codec_host_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              need,
    input  logic              give,
    input  logic [7:0]        din,
    input  logic [2:0]        nbytes,
    output logic              req,
    output logic [WORD_W-1:0] word_out,
    output logic              vld,
    output logic              done
);

    localparam int NB    = WORD_W / 8;
    localparam int PTR_W = $clog2(NB);

    play_state_t       state_q, state_d;
    logic [WORD_W-1:0] word_q, word_nx;
    logic [PTR_W-1:0]  ptr_q, last_q;
    logic              at_last;

    assign at_last = ptr_q == last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PLAY_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PLAY_IDLE: if (en && need)      state_d = PLAY_FILL;
            PLAY_FILL: if (give && at_last) state_d = PLAY_IDLE;
            default:   state_d = PLAY_IDLE;
        endcase
    end

    always_comb begin
        word_nx = word_q;
        for (int b = 0; b < NB; b++)
            if (ptr_q == PTR_W'(b)) word_nx[b*8 +: 8] = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q   <= '0;
            ptr_q    <= '0;
            last_q   <= '0;
            word_out <= '0;
            vld      <= 1'b0;
        end else begin
            vld <= 1'b0;
            if (state_q == PLAY_IDLE && en && need) begin
                word_q <= '0;
                ptr_q  <= '0;
                last_q <= PTR_W'(nbytes - 3'd1);
            end else if (state_q == PLAY_FILL && give) begin
                word_q <= word_nx;
                ptr_q  <= ptr_q + 1'b1;
                if (at_last) begin
                    word_out <= word_nx;
                    vld      <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        req  = state_q == PLAY_FILL;
        done = (state_q == PLAY_FILL) && give && at_last;
    end

    assert_play_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req) |-> $past(give));

    assert_play_vld_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> $fell(req));

endmodule

// File: rtl/codec_host_if.sv
module codec_host_if
    import codec_host_pkg::*;
#(
    parameter int NUM_CTRL    = 21,
    parameter int IDX_W       = 5,
    parameter int WORD_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [1:0]        addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              xcvr_en_n,
    output logic              xcvr_dir,
    input  logic              cap_ack_n,
    output logic              cap_req,
    input  logic              play_ack_n,
    output logic              play_req,
    output logic              irq,
    input  logic              cap_smp_vld,
    input  logic [WORD_W-1:0] cap_smp,
    input  logic              play_need,
    output logic [WORD_W-1:0] play_smp,
    output logic              play_smp_vld
);

    commit_t          cmt;
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       data_rd, cap_byte;
    logic [2:0]       nbytes;
    logic             play_en, cap_en;
    logic             cap_take, play_give, cap_done, play_done;
    logic             dma_sel;

    codec_bus_fsm #(
        .SYNC_STAGES(SYNC_STAGES),
        .ADDR_W     (2),
        .DATA_W     (8)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .addr      (addr),
        .din       (din),
        .cap_ack_n (cap_ack_n),
        .play_ack_n(play_ack_n),
        .cmt       (cmt)
    );

    codec_ctrl_regs #(
        .NUM_CTRL(NUM_CTRL),
        .IDX_W   (IDX_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (cmt.reg_wr),
        .wr_addr    (cmt.addr),
        .wr_data    (cmt.data),
        .sample_done(cap_done || play_done),
        .idx_q      (idx_q),
        .data_rd    (data_rd),
        .nbytes     (nbytes),
        .play_en    (play_en),
        .cap_en     (cap_en),
        .irq        (irq)
    );

    assign cap_take  = cmt.cap_rd  || (cmt.reg_rd && cmt.addr == 2'd3);
    assign play_give = cmt.play_wr || (cmt.reg_wr && cmt.addr == 2'd3);

    codec_cap_lane #(.WORD_W(WORD_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cap_en),
        .smp_vld (cap_smp_vld),
        .smp     (cap_smp),
        .nbytes  (nbytes),
        .take    (cap_take),
        .req     (cap_req),
        .byte_out(cap_byte),
        .done    (cap_done)
    );

    codec_play_lane #(.WORD_W(WORD_W)) u_play (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (play_en),
        .need    (play_need),
        .give    (play_give),
        .din     (cmt.data),
        .nbytes  (nbytes),
        .req     (play_req),
        .word_out(play_smp),
        .vld     (play_smp_vld),
        .done    (play_done)
    );

    // Transceiver control follows the pins directly
    assign dma_sel   = !cap_ack_n || !play_ack_n;
    assign xcvr_en_n = !((!rd_n || !wr_n) && (!cs_n || dma_sel));
    assign xcvr_dir  = !(!rd_n && (!cs_n || dma_sel));

    always_comb begin
        if (!cap_ack_n) begin
            dout = cap_byte;
        end else begin
            unique case (addr)
                2'd0:    dout = 8'(idx_q);
                2'd1:    dout = data_rd;
                2'd2:    dout = {7'b0, irq};
                default: dout = cap_byte;
            endcase
        end
    end

    assert_irq_clear_by_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(cmt.reg_wr && cmt.addr == 2'd2));

    assert_dma_ignores_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cap_req) |-> $past(cmt.cap_rd || (cmt.reg_rd && cmt.addr == 2'd3)));

endmodule

// File: tb/codec_host_if_tb.sv
module codec_host_if_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0]  addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        xcvr_en_n, xcvr_dir;
    logic        cap_ack_n = 1'b1, play_ack_n = 1'b1;
    logic        cap_req, play_req, irq;
    logic        cap_smp_vld = 1'b0;
    logic [31:0] cap_smp = '0;
    logic        play_need = 1'b0;
    logic [31:0] play_smp;
    logic        play_smp_vld;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic [31:0] got_word = '0;

    always #10 clk = ~clk;

    codec_host_if u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .xcvr_en_n(xcvr_en_n),
        .xcvr_dir(xcvr_dir), .cap_ack_n(cap_ack_n), .cap_req(cap_req),
        .play_ack_n(play_ack_n), .play_req(play_req), .irq(irq),
        .cap_smp_vld(cap_smp_vld), .cap_smp(cap_smp), .play_need(play_need),
        .play_smp(play_smp), .play_smp_vld(play_smp_vld)
    );

    always @(posedge clk) if (play_smp_vld) got_word <= play_smp;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One host cycle; samples outputs mid-strobe
    task automatic cyc(input logic is_rd, input logic c_n, input logic ca_n,
                       input logic pa_n, input logic [1:0] a, input logic [7:0] d,
                       output logic [7:0] rdat, output logic en_s, output logic dir_s,
                       output logic creq_s, output logic preq_s);
        @(negedge clk);
        cs_n = c_n; cap_ack_n = ca_n; play_ack_n = pa_n; addr = a; din = d;
        @(negedge clk);
        if (is_rd) rd_n = 1'b0; else wr_n = 1'b0;
        repeat (3) @(negedge clk);
        rdat = dout; en_s = xcvr_en_n; dir_s = xcvr_dir;
        creq_s = cap_req; preq_s = play_req;
        rd_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1; cap_ack_n = 1'b1; play_ack_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic rwr(input logic [1:0] a, input logic [7:0] d);
        logic [7:0] r; logic e, di, cr, pr;
        cyc(1'b0, 1'b0, 1'b1, 1'b1, a, d, r, e, di, cr, pr);
    endtask

    task automatic rrd(input logic [1:0] a, output logic [7:0] r);
        logic e, di, cr, pr;
        cyc(1'b1, 1'b0, 1'b1, 1'b1, a, 8'h00, r, e, di, cr, pr);
    endtask

    task automatic ctrl(input logic [7:0] idx, input logic [7:0] val);
        rwr(2'd0, idx);
        rwr(2'd1, val);
    endtask

    task automatic pulse_cap(input logic [31:0] w);
        @(negedge clk); cap_smp = w; cap_smp_vld = 1'b1;
        @(negedge clk); cap_smp_vld = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_need();
        @(negedge clk); play_need = 1'b1;
        @(negedge clk); play_need = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // {is_read, addr, data, expected}
    localparam int NV = 12;
    localparam logic [18:0] VEC [NV] = '{
        {1'b0, 2'd0, 8'h03, 8'h00},
        {1'b0, 2'd1, 8'hA5, 8'h00},
        {1'b1, 2'd1, 8'h00, 8'hA5},
        {1'b0, 2'd0, 8'h14, 8'h00},
        {1'b0, 2'd1, 8'h3C, 8'h00},
        {1'b1, 2'd1, 8'h00, 8'h3C},
        {1'b0, 2'd0, 8'h15, 8'h00},
        {1'b0, 2'd1, 8'h77, 8'h00},
        {1'b1, 2'd1, 8'h00, 8'h00},
        {1'b1, 2'd0, 8'h00, 8'h15},
        {1'b0, 2'd0, 8'h03, 8'h00},
        {1'b1, 2'd1, 8'h00, 8'hA5}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic e, di, cr, pr;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("reset R5 cap_req", cap_req, 0);
        chk("reset R7 play_req", play_req, 0);
        chk("reset R10 irq", irq, 0);
        chk("reset R1 en_n", xcvr_en_n, 1);
        chk("reset R2 dir", xcvr_dir, 1);

        // R4 index/data table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][18]) begin
                rrd(VEC[i][17:16], r);
                chk($sformatf("R4 vec%0d", i), r, VEC[i][7:0]);
            end else begin
                rwr(VEC[i][17:16], VEC[i][15:8]);
            end
        end

        // R3: no chip select, no ack -> write ignored; R1/R2 pins idle
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 8'h07, r, e, di, cr, pr);
        chk("R1 en_n no select", e, 1);
        chk("R2 dir no select", di, 1);
        rrd(2'd0, r);
        chk("R3 index unchanged", r, 8'h03);

        // R1/R2 register read and write
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 8'h00, r, e, di, cr, pr);
        chk("R1 en_n reg read", e, 0);
        chk("R2 dir reg read", di, 0);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 8'h03, r, e, di, cr, pr);
        chk("R1 en_n reg write", e, 0);
        chk("R2 dir reg write", di, 1);

        // Setup: 16-bit stereo (R8), both enabled, count = 1 (R9)
        ctrl(8'd8, 8'h50);
        ctrl(8'd9, 8'h03);
        ctrl(8'd15, 8'h01);
        ctrl(8'd14, 8'h00);

        pulse_cap(32'h44332211);
        chk("R5 cap_req raised", cap_req, 1);
        for (int b = 0; b < 4; b++) begin
            cyc(1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 8'h00, r, e, di, cr, pr);
            chk($sformatf("R6 R8 cap byte %0d", b), r, 8'h11 * (b + 1));
            if (b == 0) begin
                chk("R1 en_n dma read", e, 0);
                chk("R2 dir dma read", di, 0);
            end
            if (b == 3) chk("R11 req high in last strobe", cr, 1);
            else        chk("R5 req held", cap_req, 1);
        end
        chk("R5 cap_req dropped", cap_req, 0);
        chk("R9 no irq at count 1", irq, 0);

        // Playback 16-bit mono: 2 bytes
        ctrl(8'd8, 8'h40);
        pulse_need();
        chk("R7 play_req raised", play_req, 1);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 8'hCD, r, e, di, cr, pr);
        chk("R1 en_n dma write", e, 0);
        chk("R7 play_req held", play_req, 1);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 8'hAB, r, e, di, cr, pr);
        chk("R11 play req high in last strobe", pr, 1);
        chk("R7 R8 play word", got_word, 32'h0000ABCD);
        chk("R7 play_req dropped", play_req, 0);
        chk("R9 irq on underflow", irq, 1);
        rrd(2'd2, r);
        chk("R10 status bit", r, 8'h01);
        rwr(2'd2, 8'h00);
        chk("R10 irq cleared", irq, 0);

        // 8-bit mono via PIO (R12); count reloaded to 1
        ctrl(8'd8, 8'h00);
        pulse_cap(32'h000000EE);
        chk("R5 cap_req 1-byte", cap_req, 1);
        rrd(2'd3, r);
        chk("R12 pio capture byte", r, 8'hEE);
        chk("R12 R8 cap_req dropped", cap_req, 0);
        chk("R9 reload no irq", irq, 0);

        pulse_need();
        rwr(2'd3, 8'h5A);
        chk("R12 pio play word", got_word, 32'h0000005A);
        chk("R12 play_req dropped", play_req, 0);
        chk("R9 irq second underflow", irq, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule